// File: doc/BRIEF.md
# Window Watchdog with Pulsed Fault or Latched Flag

This block checks that a host services it only inside an open window. It runs on the system clock. A one-cycle enable, `osc_tick`, marks each period of a slow oscillator, and every duration below is counted in those ticks. A window of `WIN_TICKS` ticks is split into a closed half and an open half. The first open window after an initialization lasts `FIRST_MULT` full windows. A service pulse counts only if it stays high for `SVC_MIN_TICKS` ticks. A valid service inside an open window starts a new closed window at once. A valid service inside a closed window is a violation. So is the end of an open window with no service.

The parameter `FLAG_MODE` selects how a violation is reported. With `FLAG_MODE = 0`, `fault_n` goes low for one tick period and the watchdog then restarts its first open window. With `FLAG_MODE = 1`, `flag` is set and held, `rst_req` is high for one tick period, and the watchdog halts until the next initialization.

The watchdog runs only while `wd_dis` is low and `sup_ok` (the released reset of the supervisor) is high. Initialization happens on a rising edge of `sup_ok` while enabled, or on a falling edge of `wd_dis` while `sup_ok` is high.

The controller has these states:
- IDLE: stopped.
- FIRST_OPEN: the long first window.
- CLOSED: servicing is forbidden.
- OPEN: servicing is expected.
- ALARM: one tick period of fault or request.
- HOLD: the flag variant, halted after a violation.

Its transitions are:
- disable or `sup_ok` low → IDLE.
- init → FIRST_OPEN.
- service in FIRST_OPEN or OPEN → CLOSED.
- CLOSED expiry → OPEN.
- service in CLOSED, or expiry of FIRST_OPEN or OPEN → ALARM.
- ALARM → FIRST_OPEN in the fault variant, or → HOLD in the flag variant.

Top module: `wdog_window`

## Requirements
- R1: After reset `fault_n` is 1, `flag` is 0 and `rst_req` is 0, and the block stays idle.
- R2: An initialization occurs on a rising edge of `sup_ok` while `wd_dis` is 0, or on a falling edge of `wd_dis` while `sup_ok` is 1. A rising edge of `sup_ok` while `wd_dis` is 1 starts nothing.
- R3: After an initialization, with no valid service, a violation is reported on the tick numbered `FIRST_MULT*WIN_TICKS`, counting the first tick after the initialization as 1. A valid service on that same tick is accepted.
- R4: After an accepted service, a valid service on any of the next `WIN_TICKS/2` ticks is a violation, reported on that tick.
- R5: Ticks `WIN_TICKS/2+1` to `WIN_TICKS` after an accepted service form the open window. A valid service there is accepted and restarts the closed window. With no service by tick `WIN_TICKS`, a violation is reported on that tick.
- R6: A service becomes valid on the `SVC_MIN_TICKS`-th tick on which `svc_in` has been seen high, and counts once per high pulse. A shorter pulse has no effect.
- R7: Fault variant: on a violation `fault_n` goes low for exactly one tick period (4 clocks in the bench), while `flag` and `rst_req` stay 0.
- R8: Fault variant: when the fault pulse ends while enabled with `sup_ok` high, the watchdog re-initializes, and its next violation without service follows R3 counted from that tick.
- R9: Flag variant: on a violation `flag` rises and `rst_req` is high for exactly one tick period, while `fault_n` stays 1. The watchdog then ignores services and reports nothing more until an initialization.
- R10: Flag variant: `flag` clears only on an initialization. Disabling the watchdog or dropping `sup_ok` leaves it set.
- R11: While `wd_dis` is 1 the watchdog is idle: services are ignored, no violation is reported, and a later initialization starts from FIRST_OPEN.
- R12: While `sup_ok` is 0 the watchdog is idle and reports no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| svc_in | input | 1 | Service input from the host, asynchronous |
| wd_dis | input | 1 | Watchdog disable, active high |
| sup_ok | input | 1 | Reset supervisor output, high when released |
| fault_n | output | 1 | Fault pulse, active low (fault variant) |
| flag | output | 1 | Latched violation flag (flag variant) |
| rst_req | output | 1 | Reset request pulse to the supervisor (flag variant) |

## Verification
The bench builds two copies side by side from the same stimulus: `FLAG_MODE = 0` and `FLAG_MODE = 1`. Both use `WIN_TICKS = 20` (10 closed, 10 open), `FIRST_MULT = 8` (a 160-tick first window) and `SVC_MIN_TICKS = 3`, with a tick every 4 clocks. These scaled values put every window edge within a few hundred ticks. That covers:
- the last closed tick, and the first and last open ticks;
- the last tick of the first window;
- a two-tick pulse that falls short of a service.

Every violation is placed on an exact tick number. The bench also sees the variants diverge after their first violation: the fault copy restarts, while the flag copy halts and keeps its flag through disable and `sup_ok` loss.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST_OPEN,
        ST_CLOSED,
        ST_OPEN,
        ST_ALARM,
        ST_HOLD
    } wdw_state_e;

endpackage

// File: rtl/wdw_svc_detect.sv
// Service qualifier: synchronizes the host input and raises svc_ok for
// one clock, on the tick where the pulse has been high SVC_MIN_TICKS ticks.
module wdw_svc_detect #(
    parameter int SVC_MIN_TICKS = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic svc_in,
    output logic svc_ok
);

    localparam int HI_W = $clog2(SVC_MIN_TICKS + 1);
    localparam logic [HI_W-1:0] HI_LAST = HI_W'(SVC_MIN_TICKS - 1);
    localparam logic [HI_W-1:0] HI_SAT  = HI_W'(SVC_MIN_TICKS);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HI_W-1:0]        hi_cnt_q;
    logic                   svc_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], svc_in};
        end
    end

    assign svc_s = sync_q[SYNC_STAGES-1];

    // Counts ticks of the current high pulse; saturates so one pulse
    // yields exactly one qualified service.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (!svc_s) begin
            hi_cnt_q <= '0;
        end else if (osc_tick && (hi_cnt_q != HI_SAT)) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign svc_ok = osc_tick && svc_s && (hi_cnt_q == HI_LAST);

endmodule

// File: rtl/wdw_init_ctl.sv
// Enable and initialization control from the supervisor and disable inputs.
module wdw_init_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_ok,
    input  logic wd_dis,
    output logic run_en,
    output logic init_evt
);

    logic sup_prev_q;
    logic dis_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_prev_q <= 1'b0;
            dis_prev_q <= 1'b1;
        end else begin
            sup_prev_q <= sup_ok;
            dis_prev_q <= wd_dis;
        end
    end

    assign run_en = sup_ok && !wd_dis;

    // Rising supervisor release while enabled, or enable while released.
    assign init_evt = run_en && ((!sup_prev_q) || dis_prev_q);

endmodule

// File: rtl/wdw_window_fsm.sv
// Window controller: first open window, closed/open alternation and
// violation reporting for the chosen variant.
module wdw_window_fsm
    import wdw_pkg::*;
#(
    parameter int WIN_TICKS  = 5000,
    parameter int FIRST_MULT = 8,
    parameter bit FLAG_MODE  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic run_en,
    input  logic init_evt,
    input  logic svc_ok,
    output logic fault_n,
    output logic flag,
    output logic rst_req
);

    localparam int CLOSED_TICKS = WIN_TICKS / 2;
    localparam int OPEN_TICKS   = WIN_TICKS - CLOSED_TICKS;
    localparam int FIRST_TICKS  = FIRST_MULT * WIN_TICKS;
    localparam int CNT_W        = $clog2(FIRST_TICKS + 1);

    localparam logic [CNT_W-1:0] FIRST_LAST  = CNT_W'(FIRST_TICKS - 1);
    localparam logic [CNT_W-1:0] CLOSED_LAST = CNT_W'(CLOSED_TICKS - 1);
    localparam logic [CNT_W-1:0] OPEN_LAST   = CNT_W'(OPEN_TICKS - 1);

    localparam wdw_state_e ALARM_EXIT = FLAG_MODE ? ST_HOLD : ST_FIRST_OPEN;

    wdw_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state: stop beats init, init beats the tick-driven walk
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!run_en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (init_evt) begin
            state_d = ST_FIRST_OPEN;
            cnt_d   = '0;
        end else if (osc_tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_HOLD: begin
                    state_d = ST_HOLD;
                end
                ST_FIRST_OPEN: begin
                    if (svc_ok) begin
                        state_d = ST_CLOSED;
                        cnt_d   = '0;
                    end else if (cnt_q == FIRST_LAST) begin
                        state_d = ST_ALARM;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_CLOSED: begin
                    if (svc_ok) begin
                        state_d = ST_ALARM;
                        cnt_d   = '0;
                    end else if (cnt_q == CLOSED_LAST) begin
                        state_d = ST_OPEN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (svc_ok) begin
                        state_d = ST_CLOSED;
                        cnt_d   = '0;
                    end else if (cnt_q == OPEN_LAST) begin
                        state_d = ST_ALARM;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_ALARM: begin
                    state_d = ALARM_EXIT;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Outputs, decoded per variant
    generate
        if (FLAG_MODE) begin : g_flag_out
            logic flag_q;
            logic set_flag;

            assign set_flag = (state_d == ST_ALARM) && (state_q != ST_ALARM);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q <= 1'b0;
                end else if (run_en && init_evt) begin
                    flag_q <= 1'b0;
                end else if (set_flag) begin
                    flag_q <= 1'b1;
                end
            end

            always_comb begin
                fault_n = 1'b1;
                flag    = flag_q;
                rst_req = (state_q == ST_ALARM);
            end
        end else begin : g_fault_out
            always_comb begin
                fault_n = (state_q != ST_ALARM);
                flag    = 1'b0;
                rst_req = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
    parameter int WIN_TICKS     = 5000,
    parameter int FIRST_MULT    = 8,
    parameter int SVC_MIN_TICKS = 3,
    parameter bit FLAG_MODE     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic svc_in,
    input  logic wd_dis,
    input  logic sup_ok,
    output logic fault_n,
    output logic flag,
    output logic rst_req
);

    logic svc_ok;
    logic run_en;
    logic init_evt;

    wdw_svc_detect #(
        .SVC_MIN_TICKS (SVC_MIN_TICKS),
        .SYNC_STAGES   (2)
    ) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .svc_in   (svc_in),
        .svc_ok   (svc_ok)
    );

    wdw_init_ctl u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .sup_ok   (sup_ok),
        .wd_dis   (wd_dis),
        .run_en   (run_en),
        .init_evt (init_evt)
    );

    wdw_window_fsm #(
        .WIN_TICKS  (WIN_TICKS),
        .FIRST_MULT (FIRST_MULT),
        .FLAG_MODE  (FLAG_MODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .run_en   (run_en),
        .init_evt (init_evt),
        .svc_ok   (svc_ok),
        .fault_n  (fault_n),
        .flag     (flag),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
    parameter bit FLAG_MODE = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic osc_tick,
    input logic svc_in,
    input logic wd_dis,
    input logic sup_ok,
    input logic fault_n,
    input logic flag,
    input logic rst_req,
    input logic init_evt,
    input logic svc_ok
);

    // R2
    init_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |-> (sup_ok && !wd_dis));

    // R6
    svc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !svc_ok);

    // R6
    svc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |-> $past(svc_in, 2));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(init_evt));

    // R11
    dis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_dis |=> (fault_n && !rst_req));

    // R12
    sup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> (fault_n && !rst_req));

    generate
        if (FLAG_MODE) begin : g_flag_chk
            // R9
            flag_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
                fault_n);

            // R9
            flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag) |-> rst_req);

            // R9
            req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_req && osc_tick && !init_evt) |=> !rst_req);
        end else begin : g_fault_chk
            // R7
            fault_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!flag && !rst_req));

            // R7
            fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!fault_n && !osc_tick && sup_ok && !wd_dis && !init_evt) |=> !fault_n);

            // R8
            fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!fault_n && osc_tick) |=> fault_n);
        end
    endgenerate

endmodule

bind wdog_window wdog_window_chk #(.FLAG_MODE(FLAG_MODE)) u_wdog_window_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .svc_in   (svc_in),
    .wd_dis   (wd_dis),
    .sup_ok   (sup_ok),
    .fault_n  (fault_n),
    .flag     (flag),
    .rst_req  (rst_req),
    .init_evt (init_evt),
    .svc_ok   (svc_ok)
);

// File: tb/wdog_window_bench.sv
`timescale 1ns/1ps
module wdog_window_bench;

    localparam int WIN   = 20;
    localparam int MULT  = 8;
    localparam int SVC   = 3;
    localparam int FIRST = WIN * MULT;
    localparam int HALF  = WIN / 2;
    localparam int TDIV  = 4;

    localparam int EV_FAULT = 1;
    localparam int EV_FLAG  = 2;
    localparam int EV_CLR   = 3;
    localparam int EV_REQ   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic svc_in = 1'b0;
    logic wd_dis = 1'b1;
    logic sup_ok = 1'b0;
    logic fault_n_a, flag_a, req_a;
    logic fault_n_b, flag_b, req_b;
    logic [1:0] div = 2'd0;
    int tick_no = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    tick;
        string req;
    } ev_t;

    ev_t q_a[$];
    ev_t q_b[$];

    always #5 clk = ~clk;

    always @(negedge clk) begin
        div      <= div + 2'd1;
        osc_tick <= (div == 2'd3);
    end

    always @(posedge clk) begin
        if (osc_tick) tick_no <= tick_no + 1;
    end

    wdog_window #(.WIN_TICKS(WIN), .FIRST_MULT(MULT), .SVC_MIN_TICKS(SVC), .FLAG_MODE(1'b0))
    u_wdog_window (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .svc_in(svc_in),
        .wd_dis(wd_dis), .sup_ok(sup_ok),
        .fault_n(fault_n_a), .flag(flag_a), .rst_req(req_a)
    );

    wdog_window #(.WIN_TICKS(WIN), .FIRST_MULT(MULT), .SVC_MIN_TICKS(SVC), .FLAG_MODE(1'b1))
    u_wdog_window_flag (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .svc_in(svc_in),
        .wd_dis(wd_dis), .sup_ok(sup_ok),
        .fault_n(fault_n_b), .flag(flag_b), .rst_req(req_b)
    );

    function automatic string kind_req(int kind);
        case (kind)
            EV_FAULT: return "R7";
            EV_CLR:   return "R10";
            default:  return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard
    task automatic expect_ev(bit b, int kind, int tick, string req);
        ev_t e;
        e.kind = kind;
        e.tick = tick;
        e.req  = req;
        if (b) q_b.push_back(e);
        else   q_a.push_back(e);
    endtask

    // Monitor side of the scoreboard
    task automatic observe(bit b, int kind);
        ev_t e;
        n_checks++;
        if ((b ? q_b.size() : q_a.size()) == 0) begin
            n_fail++;
            $display("FAIL %s copy %0d: actual event %0d at tick %0d expected none",
                     kind_req(kind), b, kind, tick_no);
        end else begin
            e = b ? q_b.pop_front() : q_a.pop_front();
            if (e.kind != kind || e.tick != tick_no) begin
                n_fail++;
                $display("FAIL %s copy %0d: actual event %0d at tick %0d expected event %0d at tick %0d",
                         e.req, b, kind, tick_no, e.kind, e.tick);
            end
        end
    endtask

    logic pa_fn = 1'b1;
    logic pb_fl = 1'b0;
    logic pb_rq = 1'b0;
    int   lo_a = 0;
    int   hi_b = 0;
    bit   wrong_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pa_fn && !fault_n_a) observe(1'b0, EV_FAULT);
            if (!fault_n_a) lo_a++;
            else if (!pa_fn) begin
                check("R7", "fault pulse length in clocks", lo_a, TDIV);
                lo_a = 0;
            end
            if (!pb_fl && flag_b) observe(1'b1, EV_FLAG);
            if (pb_fl && !flag_b) observe(1'b1, EV_CLR);
            if (!pb_rq && req_b) observe(1'b1, EV_REQ);
            if (req_b) hi_b++;
            else if (pb_rq) begin
                check("R9", "reset request length in clocks", hi_b, TDIV);
                hi_b = 0;
            end
            if (!wrong_seen && (flag_a || req_a || !fault_n_b)) begin
                wrong_seen = 1'b1;
                n_checks++;
                n_fail++;
                $display("FAIL R9 variant output leak: actual flag_a=%0b req_a=%0b fault_n_b=%0b expected 0 0 1",
                         flag_a, req_a, fault_n_b);
            end
            pa_fn = fault_n_a;
            pb_fl = flag_b;
            pb_rq = req_b;
        end
    end

    task automatic wait_tick();
        @(posedge clk iff osc_tick);
        @(negedge clk);
    endtask

    task automatic wait_until(int t);
        while (tick_no < t) wait_tick();
    endtask

    // Valid service lands exactly on tick 'target'
    task automatic serve(int target);
        wait_until(target - SVC);
        svc_in = 1'b1;
        wait_until(target);
        svc_in = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired for R1 to R12 run: actual hung expected finished");
        finish_run();
    end

    initial begin
        int ts, t0, s1, s2, s3, t1, s4, t2, s5, t3, s6, s7, s8, t4, s9, t5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "fault_n fault copy", fault_n_a, 1);
        check("R1", "flag fault copy", flag_a, 0);
        check("R1", "rst_req fault copy", req_a, 0);
        check("R1", "fault_n flag copy", fault_n_b, 1);
        check("R1", "flag flag copy", flag_b, 0);
        check("R1", "rst_req flag copy", req_b, 0);

        // R2: supervisor release while disabled starts nothing
        wait_tick();
        ts = tick_no;
        wait_until(ts + 3);
        sup_ok = 1'b1;
        wait_until(ts + 3 + FIRST + 40);
        check("R2", "fault_n after release while disabled", fault_n_a, 1);

        // R2: enabling while released initializes
        wd_dis = 1'b0;
        t0 = tick_no;

        // R3 in-window service, R5 open service, R6 short pulse ignored
        s1 = t0 + 50;
        serve(s1);
        s2 = s1 + 15;
        serve(s2);
        wait_until(s2 + 10);
        svc_in = 1'b1;
        wait_until(s2 + 12);
        svc_in = 1'b0;
        s3 = s2 + 18;
        serve(s3);

        // R5 missed open window: both copies report
        expect_ev(1'b0, EV_FAULT, s3 + WIN, "R5");
        expect_ev(1'b1, EV_FLAG, s3 + WIN, "R9");
        expect_ev(1'b1, EV_REQ, s3 + WIN, "R9");
        t1 = s3 + WIN + 1;

        // R8 fault copy restarted; R4 service in closed window
        s4 = t1 + 5;
        serve(s4);
        expect_ev(1'b0, EV_FAULT, s4 + 4, "R4");
        serve(s4 + 4);
        t2 = s4 + 5;
        wait_until(t2);
        check("R9", "flag held while halted", flag_b, 1);

        // R4 boundary: last closed tick
        s5 = t2 + 10;
        serve(s5);
        expect_ev(1'b0, EV_FAULT, s5 + HALF, "R4");
        serve(s5 + HALF);
        t3 = s5 + HALF + 1;

        // R5 boundaries: first and last open ticks accepted
        s6 = t3 + 3;
        serve(s6);
        s7 = s6 + HALF + 1;
        serve(s7);
        s8 = s7 + WIN;
        serve(s8);

        // R12 supervisor low idles; R10 flag survives
        wait_until(s8 + 5);
        sup_ok = 1'b0;
        wait_until(s8 + 40);
        check("R12", "fault_n while sup_ok low", fault_n_a, 1);
        check("R10", "flag kept while sup_ok low", flag_b, 1);
        t4 = tick_no;
        expect_ev(1'b1, EV_CLR, t4, "R10");
        sup_ok = 1'b1;

        // R3 boundary: service on last tick of first window
        s9 = t4 + FIRST;
        serve(s9);

        // R11 disable: services ignored, no report
        wait_until(s9 + 2);
        wd_dis = 1'b1;
        serve(s9 + 10);
        wait_until(s9 + 60);
        check("R11", "fault_n while disabled", fault_n_a, 1);
        check("R10", "flag after re-init", flag_b, 0);

        // R3 first window expiry after re-enable (R11 restart)
        wd_dis = 1'b0;
        t5 = tick_no;
        expect_ev(1'b0, EV_FAULT, t5 + FIRST, "R3");
        expect_ev(1'b1, EV_FLAG, t5 + FIRST, "R3");
        expect_ev(1'b1, EV_REQ, t5 + FIRST, "R3");
        wait_until(t5 + FIRST + 5);
        wd_dis = 1'b1;
        wait_until(t5 + FIRST + 35);
        check("R10", "flag kept through disable", flag_b, 1);
        check("R11", "fault_n after disable", fault_n_a, 1);
        check("R8", "pending fault copy events", q_a.size(), 0);
        check("R9", "pending flag copy events", q_b.size(), 0);
        finish_run();
    end

endmodule